// File: doc/BRIEF.md
# Media Port Selector (Twisted Pair / AUI)

This block decides which of two media ports of a 10 Mb/s Ethernet transceiver carries data: the twisted-pair port or the attachment unit interface (AUI) port. In manual mode a single port-select pin is read as an input. A 1 picks twisted pair and a 0 picks AUI. In automatic mode the same pin is turned around and driven by the block, reporting the port it chose. The choice follows a "twisted-pair link valid" indication, which is filtered against brief dropouts.

The block also steers the surrounding media logic. It enables link-pulse generation, parks the outputs of the unused port in their standby state, and opens a settling window after every port change. During that window data transfer is gated off; the window is nominally 1 ms and is counted in reference clock cycles. While the chip is in its low-power standby, the select pin is released (not driven) and the current choice is held.

The selection machine has four states:
- `PS_AUI_RUN`: AUI chosen and usable.
- `PS_AUI_SETTLE`: AUI chosen, still settling.
- `PS_TP_RUN`: twisted pair chosen and usable.
- `PS_TP_SETTLE`: twisted pair chosen, still settling.

The transitions are:
- A RUN state goes to the opposite port's SETTLE state when the wanted port differs from the current one.
- A SETTLE state goes to the opposite SETTLE state when the wanted port flips again. This restarts the window.
- A SETTLE state goes to its own RUN state when the window expires.
- No port change is taken while `standby` is high.

The wanted port is `link_filt` in automatic mode and `port_en_in` in manual mode.

Top module: `media_port_sel`

## Requirements
- R1: After reset the AUI port is selected (`tp_sel`=0), `settling`=0, `data_ok`=1, and `port_en_oe`=0 while `auto_sel`=0.
- R2: With `auto_sel`=0 the selection follows `port_en_in` (1 = twisted pair, 0 = AUI) from the next clock edge, and `port_en_oe` stays 0.
- R3: With `auto_sel`=1 and `standby`=0, `port_en_oe`=1 and `port_en_out` reports the chosen port (1 = twisted pair, 0 = AUI).
- R4: With `auto_sel`=1 the block selects twisted pair when the filtered link indication is 1 and AUI when it is 0.
- R5: The filtered link indication changes only after `link_ok` has differed from it on DEB_CYC consecutive clock edges. A shorter excursion has no effect on the selection.
- R6: Every change of the selected port raises `settling` and drops `data_ok` for exactly SETTLE_CYC cycles. A further change during the window restarts it at full length.
- R7: `aui_out_standby`=1 exactly when twisted pair is selected. `tp_out_standby`=1 and `tp_pulse_en`=0 only when AUI is selected with `auto_sel`=0. An automatically chosen AUI keeps link pulses on and the twisted-pair outputs active.
- R8: While `standby`=1, `port_en_oe`=0 and the selected port does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Chip low-power standby |
| auto_sel | input | 1 | 1 = automatic port choice, 0 = manual |
| port_en_in | input | 1 | Select pin as read (manual choice) |
| link_ok | input | 1 | Twisted-pair link valid (link beats or frames seen) |
| port_en_out | output | 1 | Value driven onto select pin in automatic mode |
| port_en_oe | output | 1 | Output enable for the select pin |
| tp_sel | output | 1 | 1 = twisted pair selected, 0 = AUI |
| settling | output | 1 | Settling window after a port change is open |
| data_ok | output | 1 | Transmit and receive on the selected port allowed |
| tp_pulse_en | output | 1 | Twisted-pair link pulse generation enabled |
| tp_out_standby | output | 1 | Twisted-pair outputs parked in standby |
| aui_out_standby | output | 1 | AUI outputs parked in standby |

## Verification
A wrong state in the selection machine shows up on `tp_sel` and the standby outputs one cycle after the input that should have moved it. A stuck or mis-loaded settling timer shows as `data_ok` returning one or more cycles early or late against the SETTLE_CYC count. A faulty link filter shows as a port change after a too-short `link_ok` pulse, or as a change on the wrong edge relative to DEB_CYC. The sweeps over every combination of mode, pin and link level therefore compare the outputs both at exact edge counts and after the outputs have settled.

// File: rtl/psel_pkg.sv
package psel_pkg;

    typedef enum logic [1:0] {
        PS_AUI_RUN    = 2'd0,
        PS_AUI_SETTLE = 2'd1,
        PS_TP_RUN     = 2'd2,
        PS_TP_SETTLE  = 2'd3
    } psel_state_t;

endpackage

// File: rtl/psel_link_filter.sv
module psel_link_filter #(
    parameter int DEB_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int DW = $clog2(DEB_CYC + 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (cnt == DW'(DEB_CYC - 1)) begin
            filt <= raw;
            cnt  <= '0;
        end else begin
            cnt <= cnt + DW'(1);
        end
    end

    AST_FILT_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt) |-> (filt == $past(raw))); // R5
    AST_FILT_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt) |-> ($past(cnt) == DW'(DEB_CYC - 1))); // R5

endmodule

// File: rtl/psel_settle_timer.sv
module psel_settle_timer #(
    parameter int SETTLE_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CW'(SETTLE_CYC - 1);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign expired = (cnt == '0);

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !load) |=> (cnt == $past(cnt) - CW'(1))); // R6

endmodule

// File: rtl/media_port_sel.sv
module media_port_sel #(
    parameter int SETTLE_CYC = 20000,
    parameter int DEB_CYC    = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic auto_sel,
    input  logic port_en_in,
    input  logic link_ok,
    output logic port_en_out,
    output logic port_en_oe,
    output logic tp_sel,
    output logic settling,
    output logic data_ok,
    output logic tp_pulse_en,
    output logic tp_out_standby,
    output logic aui_out_standby
);
    import psel_pkg::*;

    psel_state_t state, state_nx;
    logic        link_filt;
    logic        want_tp;
    logic        tmr_load;
    logic        tmr_expired;

    psel_link_filter #(.DEB_CYC(DEB_CYC)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (link_ok),
        .filt (link_filt)
    );

    psel_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .expired(tmr_expired)
    );

    assign want_tp = auto_sel ? link_filt : port_en_in;

    // next state
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        unique case (state)
            PS_AUI_RUN: begin
                if (!standby && want_tp) begin
                    state_nx = PS_TP_SETTLE;
                    tmr_load = 1'b1;
                end
            end
            PS_AUI_SETTLE: begin
                if (!standby && want_tp) begin
                    state_nx = PS_TP_SETTLE;
                    tmr_load = 1'b1;
                end else if (tmr_expired) begin
                    state_nx = PS_AUI_RUN;
                end
            end
            PS_TP_RUN: begin
                if (!standby && !want_tp) begin
                    state_nx = PS_AUI_SETTLE;
                    tmr_load = 1'b1;
                end
            end
            PS_TP_SETTLE: begin
                if (!standby && !want_tp) begin
                    state_nx = PS_AUI_SETTLE;
                    tmr_load = 1'b1;
                end else if (tmr_expired) begin
                    state_nx = PS_TP_RUN;
                end
            end
            default: state_nx = PS_AUI_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= PS_AUI_RUN;
        else
            state <= state_nx;
    end

    // outputs
    always_comb begin
        tp_sel          = (state == PS_TP_RUN) || (state == PS_TP_SETTLE);
        settling        = (state == PS_AUI_SETTLE) || (state == PS_TP_SETTLE);
        data_ok         = !settling;
        port_en_oe      = auto_sel && !standby;
        port_en_out     = tp_sel;
        tp_pulse_en     = tp_sel || auto_sel;
        tp_out_standby  = !tp_sel && !auto_sel;
        aui_out_standby = tp_sel;
    end

    AST_SWITCH_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tp_sel) |-> settling); // R6
    AST_STANDBY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(standby) |-> $stable(tp_sel)); // R8
    AST_MANUAL_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!auto_sel && !standby) && !$stable(tp_sel)) |-> (tp_sel == $past(port_en_in))); // R2

endmodule

// File: tb/sim_media_port_sel.sv
`timescale 1ns/1ps
module sim_media_port_sel;
    localparam int S = 6;
    localparam int D = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby = 1'b0, auto_sel = 1'b0, port_en_in = 1'b0, link_ok = 1'b0;
    logic port_en_out, port_en_oe, tp_sel, settling, data_ok;
    logic tp_pulse_en, tp_out_standby, aui_out_standby;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    media_port_sel #(.SETTLE_CYC(S), .DEB_CYC(D)) u0 (
        .clk(clk), .rst_n(rst_n), .standby(standby), .auto_sel(auto_sel),
        .port_en_in(port_en_in), .link_ok(link_ok), .port_en_out(port_en_out),
        .port_en_oe(port_en_oe), .tp_sel(tp_sel), .settling(settling),
        .data_ok(data_ok), .tp_pulse_en(tp_pulse_en),
        .tp_out_standby(tp_out_standby), .aui_out_standby(aui_out_standby)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1", "tp_sel", tp_sel, 1'b0);
        chk("R1", "settling", settling, 1'b0);
        chk("R1", "data_ok", data_ok, 1'b1);
        chk("R1", "port_en_oe", port_en_oe, 1'b0);

        // R2 manual select twisted pair, R6 window length
        port_en_in = 1'b1;
        step(1);
        chk("R2", "tp_sel", tp_sel, 1'b1);
        chk("R6", "settling open", settling, 1'b1);
        chk("R6", "data_ok gated", data_ok, 1'b0);
        step(S - 1);
        chk("R6", "settling last cycle", settling, 1'b1);
        step(1);
        chk("R6", "data_ok after window", data_ok, 1'b1);
        chk("R7", "aui_out_standby", aui_out_standby, 1'b1);
        chk("R7", "tp_out_standby", tp_out_standby, 1'b0);
        chk("R2", "port_en_oe", port_en_oe, 1'b0);

        // R7 manual AUI parks twisted pair
        port_en_in = 1'b0;
        step(1);
        chk("R2", "tp_sel to AUI", tp_sel, 1'b0);
        chk("R7", "tp_out_standby manual AUI", tp_out_standby, 1'b1);
        chk("R7", "tp_pulse_en manual AUI", tp_pulse_en, 1'b0);
        step(2);
        // R6 restart during window
        port_en_in = 1'b1;
        step(1);
        chk("R6", "reversal tp_sel", tp_sel, 1'b1);
        step(S - 1);
        chk("R6", "restarted window still open", settling, 1'b1);
        step(1);
        chk("R6", "restarted window closed", data_ok, 1'b1);

        // R3/R4 automatic with no link -> AUI
        port_en_in = 1'b0;
        auto_sel = 1'b1;
        step(1);
        chk("R4", "auto no link tp_sel", tp_sel, 1'b0);
        chk("R3", "port_en_oe", port_en_oe, 1'b1);
        chk("R3", "port_en_out", port_en_out, 1'b0);
        chk("R7", "auto AUI pulses", tp_pulse_en, 1'b1);
        chk("R7", "auto AUI tp active", tp_out_standby, 1'b0);
        step(S);
        chk("R6", "auto window closed", data_ok, 1'b1);

        // R5 short link pulse ignored
        link_ok = 1'b1;
        step(D - 1);
        link_ok = 1'b0;
        step(6);
        chk("R5", "short link ignored tp_sel", tp_sel, 1'b0);
        chk("R5", "short link no window", settling, 1'b0);

        // R5 full-length link accepted on exact edge
        link_ok = 1'b1;
        step(D);
        chk("R5", "not yet switched", tp_sel, 1'b0);
        step(1);
        chk("R4", "link valid tp_sel", tp_sel, 1'b1);
        chk("R3", "port_en_out tp", port_en_out, 1'b1);
        step(S);

        // R8 standby
        standby = 1'b1;
        #1;
        chk("R8", "port_en_oe in standby", port_en_oe, 1'b0);
        link_ok = 1'b0;
        step(D + 4);
        chk("R8", "frozen in standby", tp_sel, 1'b1);
        standby = 1'b0;
        step(1);
        chk("R8", "moves after standby", tp_sel, 1'b0);
        chk("R6", "window after standby", settling, 1'b1);
        step(S);

        // sweep of mode, pin and link level
        for (int a = 0; a < 2; a++) begin
            for (int p = 0; p < 2; p++) begin
                for (int l = 0; l < 2; l++) begin
                    logic exp_tp;
                    auto_sel   = a[0];
                    port_en_in = p[0];
                    link_ok    = l[0];
                    exp_tp     = a[0] ? l[0] : p[0];
                    step(D + S + 4);
                    chk(a[0] ? "R4" : "R2", "sweep tp_sel", tp_sel, exp_tp);
                    chk("R6", "sweep data_ok", data_ok, 1'b1);
                    chk("R3", "sweep port_en_oe", port_en_oe, a[0]);
                    if (a[0]) chk("R3", "sweep port_en_out", port_en_out, exp_tp);
                    chk("R7", "sweep tp_pulse_en", tp_pulse_en, exp_tp | a[0]);
                    chk("R7", "sweep tp_out_standby", tp_out_standby, !exp_tp && !a[0]);
                    chk("R7", "sweep aui_out_standby", aui_out_standby, exp_tp);
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule